// File: doc/BRIEF.md
# Pipelined Multiply-Add Unit with Adder Collision Fault

This unit is a fully pipelined integer arithmetic slot that accepts one operation per clock: a multiply, an add, or a fused multiply-add. Operands are 16-bit signed values and every result is 32 bits wide. A multiply completes 4 cycles after issue, an add 2 cycles after issue, and a fused multiply-add 5 cycles after issue. The fused operation has no adder of its own. When its product leaves the fourth multiplier stage, it goes straight into the same adder stage that stand-alone adds use.

Sharing the adder creates a structural hazard. An add issued exactly three cycles after a fused multiply-add needs the adder in the same cycle as that fused operation's accumulation step. The unit does not corrupt either result in that case. The fused operation keeps the adder, the add is dropped, and a one-cycle fault pulse carries the tag of the dropped add. The pulse appears in the cycle where the add's result would have been delivered.

Each operation carries a tag that comes back with its result. Each latency class has its own valid/result/tag output group, so completions from different classes that land in the same cycle are all delivered. A scheduler upstream is expected to avoid the hazard; the fault tells it when it did not.

Top module: `mac_pipe`

## Requirements
- R1: An add (op code 2'b01) returns the sign-extended sum a+b on the add output group 2 cycles after issue, together with its issue tag.
- R2: A multiply (op code 2'b00) returns the 32-bit signed product a*b on the multiply output group 4 cycles after issue, together with its issue tag.
- R3: A fused multiply-add (op code 2'b10) returns a*b+c modulo 2^32 on the fused output group 5 cycles after issue, together with its issue tag.
- R4: One operation is accepted every cycle, in any mix of kinds, and every accepted operation that is not dropped under R6 produces exactly one result.
- R5: Results are delivered by latency, not by issue order. A shorter operation may complete before a longer one issued earlier, and completions of different kinds in the same cycle all appear on their own output groups.
- R6: An add issued exactly 3 cycles after a fused multiply-add produces no add result. Instead, `fault` is high for one cycle, 2 cycles after the add's issue, with `fault_tag` equal to the add's tag. The fused multiply-add still completes correctly.
- R7: An add issued 1, 2, 4 or more cycles after a fused multiply-add, or in the same cycle slot sequence otherwise, raises no fault and completes normally.
- R8: A cycle with `in_valid` low, or with op code 2'b11, issues nothing and produces no output or fault.
- R9: While reset is asserted and right after it, all valid outputs and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 2 | 00 multiply, 01 add, 10 fused multiply-add, 11 nothing |
| in_a | input | 16 | Signed operand a |
| in_b | input | 16 | Signed operand b |
| in_c | input | 16 | Signed addend for the fused operation |
| in_tag | input | 4 | Tag returned with the result |
| add_valid | output | 1 | Add result valid |
| add_result | output | 32 | Add result |
| add_tag | output | 4 | Add tag |
| mul_valid | output | 1 | Multiply result valid |
| mul_result | output | 32 | Multiply result |
| mul_tag | output | 4 | Multiply tag |
| fma_valid | output | 1 | Fused result valid |
| fma_result | output | 32 | Fused result |
| fma_tag | output | 4 | Fused tag |
| fault | output | 1 | One-cycle collision pulse |
| fault_tag | output | 4 | Tag of the dropped add |

## Verification
The bench sweeps every ordered pair of operation kinds at issue gaps from one to six cycles, so the add-after-fused offset of exactly three cycles is hit next to its neighbours. An off-by-one hazard window would fault at gap 2 or 4, or miss gap 3. A design that let the add win would give a wrong fused result; one that dropped the add silently would show a missing result with no fault pulse. Extreme operands such as -32768 squared and long pseudo-random mixed streams check sign handling, 32-bit wrap and same-cycle completions on separate outputs. Mis-routed tags or results leaking onto the wrong group show up in those streams.

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [TW-1:0] in_tag,
  output logic          add_valid,
  output logic [2*DW-1:0] add_result,
  output logic [TW-1:0] add_tag,
  output logic          mul_valid,
  output logic [2*DW-1:0] mul_result,
  output logic [TW-1:0] mul_tag,
  output logic          fma_valid,
  output logic [2*DW-1:0] fma_result,
  output logic [TW-1:0] fma_tag,
  output logic          fault,
  output logic [TW-1:0] fault_tag
);
  localparam int RW = 2 * DW;
  localparam int PS = 3;
  localparam logic [1:0] OP_MUL = 2'd0;
  localparam logic [1:0] OP_ADD = 2'd1;
  localparam logic [1:0] OP_FMA = 2'd2;

  logic          m1_v, m1_f;
  logic [DW-1:0] m1_a, m1_b, m1_c;
  logic [TW-1:0] m1_t;

  logic          mp_v [PS];
  logic          mp_f [PS];
  logic [RW-1:0] mp_p [PS];
  logic [DW-1:0] mp_c [PS];
  logic [TW-1:0] mp_t [PS];

  logic          a1_v;
  logic [DW-1:0] a1_a, a1_b;
  logic [TW-1:0] a1_t;

  logic          r_add_v, r_fma_v, r_flt;
  logic [RW-1:0] r_sum;
  logic [TW-1:0] r_tag, r_flt_tag;

  wire take_mul = in_valid && (in_op == OP_MUL || in_op == OP_FMA);
  wire take_add = in_valid && (in_op == OP_ADD);

  wire [RW-1:0] prod = {{DW{m1_a[DW-1]}}, m1_a} * {{DW{m1_b[DW-1]}}, m1_b};

  wire          acc_fma = mp_v[PS-1] && mp_f[PS-1];
  wire [RW-1:0] sum_x   = acc_fma ? mp_p[PS-1] : {{DW{a1_a[DW-1]}}, a1_a};
  wire [RW-1:0] sum_y   = acc_fma ? {{DW{mp_c[PS-1][DW-1]}}, mp_c[PS-1]}
                                  : {{DW{a1_b[DW-1]}}, a1_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_v <= 1'b0; m1_f <= 1'b0;
      m1_a <= '0; m1_b <= '0; m1_c <= '0; m1_t <= '0;
      a1_v <= 1'b0; a1_a <= '0; a1_b <= '0; a1_t <= '0;
      r_add_v <= 1'b0; r_fma_v <= 1'b0; r_flt <= 1'b0;
      r_sum <= '0; r_tag <= '0; r_flt_tag <= '0;
      for (int i = 0; i < PS; i++) begin
        mp_v[i] <= 1'b0; mp_f[i] <= 1'b0;
        mp_p[i] <= '0; mp_c[i] <= '0; mp_t[i] <= '0;
      end
    end else begin
      m1_v <= take_mul;
      m1_f <= in_op == OP_FMA;
      m1_a <= in_a; m1_b <= in_b; m1_c <= in_c; m1_t <= in_tag;

      mp_v[0] <= m1_v; mp_f[0] <= m1_f;
      mp_p[0] <= prod; mp_c[0] <= m1_c; mp_t[0] <= m1_t;
      for (int i = 1; i < PS; i++) begin
        mp_v[i] <= mp_v[i-1]; mp_f[i] <= mp_f[i-1];
        mp_p[i] <= mp_p[i-1]; mp_c[i] <= mp_c[i-1]; mp_t[i] <= mp_t[i-1];
      end

      a1_v <= take_add;
      a1_a <= in_a; a1_b <= in_b; a1_t <= in_tag;

      r_sum     <= sum_x + sum_y;
      r_tag     <= acc_fma ? mp_t[PS-1] : a1_t;
      r_add_v   <= a1_v && !acc_fma;
      r_fma_v   <= acc_fma;
      r_flt     <= a1_v && acc_fma;
      r_flt_tag <= a1_t;
    end
  end

  assign add_valid  = r_add_v;
  assign add_result = r_sum;
  assign add_tag    = r_tag;
  assign fma_valid  = r_fma_v;
  assign fma_result = r_sum;
  assign fma_tag    = r_tag;
  assign mul_valid  = mp_v[PS-1] && !mp_f[PS-1];
  assign mul_result = mp_p[PS-1];
  assign mul_tag    = mp_t[PS-1];
  assign fault      = r_flt;
  assign fault_tag  = r_flt_tag;

  AST_ADD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid |-> $past(in_valid && in_op == OP_ADD, 2));  // R1
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid |-> $past(in_valid && in_op == OP_MUL, 4));  // R2
  AST_FMA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fma_valid |-> $past(in_valid && in_op == OP_FMA, 5));  // R3
  AST_FAULT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(in_valid && in_op == OP_ADD, 2) && $past(in_valid && in_op == OP_FMA, 5)));  // R6
  AST_FAULT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_tag == $past(in_tag, 2));  // R6
  AST_FAULT_KEEPS_FMA: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fma_valid && !add_valid));  // R6
  AST_ONE_ADDER_USER: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_valid && fma_valid));  // R5
endmodule

// File: tb/tb_mac_pipe.sv
module tb_mac_pipe;
  localparam int N = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'd3;
  logic [15:0] in_a = '0, in_b = '0, in_c = '0;
  logic [3:0] in_tag = '0;
  logic add_valid, mul_valid, fma_valid, fault;
  logic [31:0] add_result, mul_result, fma_result;
  logic [3:0] add_tag, mul_tag, fma_tag, fault_tag;

  mac_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_tag(in_tag),
    .add_valid(add_valid), .add_result(add_result), .add_tag(add_tag),
    .mul_valid(mul_valid), .mul_result(mul_result), .mul_tag(mul_tag),
    .fma_valid(fma_valid), .fma_result(fma_result), .fma_tag(fma_tag),
    .fault(fault), .fault_tag(fault_tag)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, n = 0;
  bit finished = 0;
  string ctx = "";
  logic ea_v [N], em_v [N], ef_v [N], ex_v [N], fma_at [N];
  logic [31:0] ea_r [N], em_r [N], ef_r [N];
  logic [3:0] ea_t [N], em_t [N], ef_t [N], ex_t [N];
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input string req, input logic av, input logic ev,
                     input logic [31:0] ar, input logic [31:0] er,
                     input logic [3:0] at, input logic [3:0] et);
    checks++;
    if (av !== ev || (ev && (ar !== er || at !== et))) begin
      errors++;
      $display("FAIL %s %s cycle %0d: valid=%b res=%h tag=%h expected valid=%b res=%h tag=%h",
               req, ctx, n, av, ar, at, ev, er, et);
    end
  endtask

  task automatic check_now();
    chk("R1 add", add_valid, ea_v[n], add_result, ea_r[n], add_tag, ea_t[n]);
    chk("R2 mul", mul_valid, em_v[n], mul_result, em_r[n], mul_tag, em_t[n]);
    chk("R3 fma", fma_valid, ef_v[n], fma_result, ef_r[n], fma_tag, ef_t[n]);
    chk("R6 fault", fault, ex_v[n], 32'd0, 32'd0, fault_tag, ex_t[n]);
  endtask

  task automatic step(input logic v, input logic [1:0] op,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    int sa, sb, sc;
    logic [3:0] t;
    @(negedge clk);
    check_now();
    t = n[3:0];
    in_valid = v; in_op = op; in_a = a; in_b = b; in_c = c; in_tag = t;
    sa = int'($signed(a)); sb = int'($signed(b)); sc = int'($signed(c));
    if (v && op == 2'd0) begin
      em_v[n+4] = 1'b1; em_r[n+4] = 32'(sa * sb); em_t[n+4] = t;
    end else if (v && op == 2'd1) begin
      if (n >= 3 && fma_at[n-3]) begin
        ex_v[n+2] = 1'b1; ex_t[n+2] = t;
      end else begin
        ea_v[n+2] = 1'b1; ea_r[n+2] = 32'(sa + sb); ea_t[n+2] = t;
      end
    end else if (v && op == 2'd2) begin
      fma_at[n] = 1'b1;
      ef_v[n+5] = 1'b1; ef_r[n+5] = 32'(sa * sb + sc); ef_t[n+5] = t;
    end
    n++;
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h0001;
      default: return 16'h1234;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      ea_v[i] = 0; em_v[i] = 0; ef_v[i] = 0; ex_v[i] = 0; fma_at[i] = 0;
      ea_r[i] = 0; em_r[i] = 0; ef_r[i] = 0;
      ea_t[i] = 0; em_t[i] = 0; ef_t[i] = 0; ex_t[i] = 0;
    end
    // R9: outputs quiet under reset
    ctx = "reset";
    repeat (3) @(negedge clk);
    chk("R9 add", add_valid, 1'b0, 32'd0, 32'd0, 4'd0, 4'd0);
    chk("R9 mul", mul_valid, 1'b0, 32'd0, 32'd0, 4'd0, 4'd0);
    chk("R9 fma", fma_valid, 1'b0, 32'd0, 32'd0, 4'd0, 4'd0);
    chk("R9 fault", fault, 1'b0, 32'd0, 32'd0, 4'd0, 4'd0);
    rst_n = 1'b1;

    // R4 R5 R7 R6: every ordered kind pair at gaps 1..6; op 3 exercises R8
    ctx = "pair-sweep R4 R5 R6 R7 R8";
    for (int k1 = 0; k1 < 3; k1++)
      for (int gap = 1; gap <= 6; gap++)
        for (int k2 = 0; k2 < 4; k2++) begin
          step(1'b1, 2'(k1), corner(k1 + gap), corner(k2 + gap + 1), corner(gap + 3));
          for (int g = 1; g < gap; g++) step(1'b0, 2'd2, 16'h5555, 16'h5555, 16'h5555);
          step(1'b1, 2'(k2), corner(k2 + 2), corner(k1 + 4), corner(k2 + gap));
          for (int g = 0; g < 6; g++) step(1'b0, 2'd0, 16'h0, 16'h0, 16'h0);
        end

    // R4 R5 R8: dense mixed stream
    ctx = "stream R4 R5 R8";
    for (int i = 0; i < 2400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[31:30] != 2'b00, lfsr[29:28], lfsr[15:0], lfsr[27:12], {lfsr[7:0], lfsr[23:16]});
    end
    ctx = "drain";
    for (int i = 0; i < 8; i++) step(1'b0, 2'd0, 16'h0, 16'h0, 16'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R4: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule